// File: doc/BRIEF.md
# Three-Device Scan Chain Sequencer

This block is a host-side engine for a test-access daisy chain of identical target devices. It generates the test clock from the system clock and drives the mode-select and serial data lines. It samples the serial return line. A single start command runs one complete transaction:
- a forced controller reset on every device;
- an instruction scan that gives one chosen device the user instruction and every other device the bypass instruction;
- a data scan that writes a byte into the chosen device's user register and returns the byte captured from that register;
- a return to Run-Test/Idle.

The block builds the scans for the whole chain. Each bypassed device adds one filler bit to the data scan and its bypass code to the instruction scan, so the stream is padded around the target's fields. An internal model of the 16-state test controller follows every mode-select bit the block sends. Completion is signalled only when that model shows Run-Test/Idle.

Sequencer states and their transitions:
- `SQ_IDLE` goes to `SQ_RESET` when a start with a valid target is accepted.
- `SQ_RESET` goes to `SQ_GO_IR` after RESET_TCKS bits.
- `SQ_GO_IR` goes to `SQ_SHIFT_IR` after 5 bits.
- `SQ_SHIFT_IR` goes to `SQ_GO_DR` after 9 bits.
- `SQ_GO_DR` goes to `SQ_SHIFT_DR` after 4 bits.
- `SQ_SHIFT_DR` goes to `SQ_PARK` after 10 bits.
- `SQ_PARK` goes to `SQ_FINISH` after 2 bits.
- `SQ_FINISH` goes to `SQ_IDLE` on the next test-clock falling edge, which also pulses done.

Each of these phase transitions is taken on the test-clock rising edge that consumes the last bit of the phase.

Top module: `jtag_chain_seq`

## Requirements
- R1: After reset, busy, done, tck, tms, tdi and rdata are all 0.
- R2: While idle, tck is held low. During a transaction, each tck half period lasts div+1 system clock cycles, where div is sampled when start is accepted, so rising edges are 2*(div+1) cycles apart.
- R3: tms and tdi change only on the system clock edge where tck falls, or on the edge where start is accepted. They hold steady while tck is high.
- R4: A transaction begins with 8 tck periods with tms=1. These are followed by tms 0,1,1,0,0, which moves every device into Shift-IR.
- R5: The instruction scan is 9 bits long and carries tms=1 only on its last bit. Device 0 is nearest the host's tdi and device 2 drives tdo. Stream bits 3g..3g+2 carry device (2-g)'s code, least-significant bit first. The target gets 3'b010 and the others get 3'b110. For target 1 the stream is 0,1,1,0,1,0,0,1,1.
- R6: After the instruction scan come tms 1,1,0,0, then a 10-bit data scan with tms=1 only on its last bit. Stream bits (2-k)..(9-k) carry wdata least-significant bit first for target k, and the two filler bits are 0. For target 1 and 0xF5 the stream is 0,1,0,1,0,1,1,1,1,0.
- R7: The transaction ends with tms 1,0, for exactly 38 tck periods in total.
- R8: rdata receives the tdo bits sampled on tck rising edges at data-scan positions (2-k)..(9-k), least-significant bit first. It changes only when a transaction completes.
- R9: done is a single system-cycle pulse, issued on the last tck falling edge only while the tracked controller state is Run-Test/Idle. busy is low in that same cycle.
- R10: A start while busy is ignored, and a start with target index 3 is ignored.
- R11: After a transaction every device is in Run-Test/Idle. The target's user register holds wdata, and the other devices keep their user registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transaction (accepted only when idle) |
| target_i | input | 2 | Index of the device to address, 0 to 2 |
| wdata_i | input | 8 | Byte written to the target's user register |
| div_i | input | 4 | TCK half period minus one, in system cycles |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte captured from the target |
| tck_o | output | 1 | Test clock to the chain |
| tms_o | output | 1 | Mode select to the chain |
| tdi_o | output | 1 | Serial data into device 0 |
| tdo_i | input | 1 | Serial data out of device 2 |

## Verification
Every target index is used with random bytes and random dividers, plus the all-zero and all-one bytes. Varying the target shows whether the bypass padding moves the user field to the right positions in both scans. Varying the byte shows bit ordering and filler placement. Each device's user register starts at a distinct value, so a read from the wrong positions or a write to the wrong device shows up on a later readback. The devices also power up in different controller states, which separates a working forced reset from one that only works from Test-Logic-Reset. A start pulse during a transaction and a start with index 3 show that both are ignored.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;

    typedef enum logic [3:0] {
        TAP_TLR,    TAP_RTI,
        TAP_SELDR,  TAP_CAPDR, TAP_SHDR,  TAP_EX1DR,
        TAP_PAUDR,  TAP_EX2DR, TAP_UPDDR,
        TAP_SELIR,  TAP_CAPIR, TAP_SHIR,  TAP_EX1IR,
        TAP_PAUIR,  TAP_EX2IR, TAP_UPDIR
    } tap_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RESET,
        SQ_GO_IR,
        SQ_SHIFT_IR,
        SQ_GO_DR,
        SQ_SHIFT_DR,
        SQ_PARK,
        SQ_FINISH
    } seq_state_e;

    function automatic tap_state_e tap_step(input tap_state_e cur, input logic tms);
        tap_state_e nxt;
        unique case (cur)
            TAP_TLR:   nxt = tms ? TAP_TLR   : TAP_RTI;
            TAP_RTI:   nxt = tms ? TAP_SELDR : TAP_RTI;
            TAP_SELDR: nxt = tms ? TAP_SELIR : TAP_CAPDR;
            TAP_CAPDR: nxt = tms ? TAP_EX1DR : TAP_SHDR;
            TAP_SHDR:  nxt = tms ? TAP_EX1DR : TAP_SHDR;
            TAP_EX1DR: nxt = tms ? TAP_UPDDR : TAP_PAUDR;
            TAP_PAUDR: nxt = tms ? TAP_EX2DR : TAP_PAUDR;
            TAP_EX2DR: nxt = tms ? TAP_UPDDR : TAP_SHDR;
            TAP_UPDDR: nxt = tms ? TAP_SELDR : TAP_RTI;
            TAP_SELIR: nxt = tms ? TAP_TLR   : TAP_CAPIR;
            TAP_CAPIR: nxt = tms ? TAP_EX1IR : TAP_SHIR;
            TAP_SHIR:  nxt = tms ? TAP_EX1IR : TAP_SHIR;
            TAP_EX1IR: nxt = tms ? TAP_UPDIR : TAP_PAUIR;
            TAP_PAUIR: nxt = tms ? TAP_EX2IR : TAP_PAUIR;
            TAP_EX2IR: nxt = tms ? TAP_UPDIR : TAP_SHIR;
            TAP_UPDIR: nxt = tms ? TAP_SELDR : TAP_RTI;
            default:   nxt = TAP_TLR;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    output logic             tck_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tck_q;
    logic             edge_w;

    assign edge_w = run_i && (cnt_q == div_q);
    assign rise_o = edge_w && !tck_q;
    assign fall_o = edge_w && tck_q;
    assign tck_o  = tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else begin
            if (load_i) begin
                div_q <= div_i;
            end
            if (!run_i) begin
                cnt_q <= '0;
                tck_q <= 1'b0;
            end else if (edge_w) begin
                cnt_q <= '0;
                tck_q <= ~tck_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/jtag_tap_tracker.sv
module jtag_tap_tracker
    import jtag_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       tms_i,
    output tap_state_e state_o,
    output logic       rti_o
);

    tap_state_e st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TAP_TLR;
        end else if (step_i) begin
            st_q <= tap_step(st_q, tms_i);
        end
    end

    assign state_o = st_q;
    assign rti_o   = (st_q == TAP_RTI);

endmodule

// File: rtl/jtag_seq_fsm.sv
module jtag_seq_fsm
    import jtag_seq_pkg::*;
#(
    parameter int                NUM_DEV    = 3,
    parameter int                IR_LEN     = 3,
    parameter int                DR_LEN     = 8,
    parameter int                RESET_TCKS = 8,
    parameter int                TGT_W      = 2,
    parameter logic [IR_LEN-1:0] USER_IR    = 3'b010,
    parameter logic [IR_LEN-1:0] BYPASS_IR  = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic [DR_LEN-1:0] wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              tdo_i,
    input  logic              tap_rti_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              tms_o,
    output logic              tdi_o,
    output logic [DR_LEN-1:0] rdata_o
);

    localparam int IR_TOTAL = NUM_DEV * IR_LEN;
    localparam int DR_TOTAL = NUM_DEV - 1 + DR_LEN;
    localparam int GO_IR_LEN = 5;
    localparam int GO_DR_LEN = 4;
    localparam int PARK_LEN  = 2;
    localparam int MAX_A   = (RESET_TCKS > IR_TOTAL) ? RESET_TCKS : IR_TOTAL;
    localparam int MAX_LEN = (MAX_A > DR_TOTAL) ? MAX_A : DR_TOTAL;
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam int VEC_W   = 1 << CNT_W;
    // Mode-select patterns, bit 0 is sent first
    localparam logic [GO_IR_LEN-1:0] GO_IR_PAT = 5'b00110;
    localparam logic [GO_DR_LEN-1:0] GO_DR_PAT = 4'b0011;
    localparam logic [PARK_LEN-1:0]  PARK_PAT  = 2'b01;

    seq_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [CNT_W-1:0]  last_idx;
    logic [TGT_W-1:0]  tgt_q;
    logic [DR_LEN-1:0] wdata_q;
    logic [DR_LEN-1:0] cap_q;
    logic              accept;
    logic              tgt_ok;
    logic              bit_tms, bit_tdi;
    logic [VEC_W-1:0]  tms_vec, tdi_vec;
    logic [IR_TOTAL-1:0] ir_vec;
    logic [DR_TOTAL-1:0] dr_vec;
    int                off;
    logic              in_window;

    assign tgt_ok = (int'(target_i) < NUM_DEV);
    assign off    = NUM_DEV - 1 - int'(tgt_q);

    // Phase length, as a last-bit index
    always_comb begin
        unique case (state_q)
            SQ_RESET:    last_idx = CNT_W'(RESET_TCKS - 1);
            SQ_GO_IR:    last_idx = CNT_W'(GO_IR_LEN - 1);
            SQ_SHIFT_IR: last_idx = CNT_W'(IR_TOTAL - 1);
            SQ_GO_DR:    last_idx = CNT_W'(GO_DR_LEN - 1);
            SQ_SHIFT_DR: last_idx = CNT_W'(DR_TOTAL - 1);
            SQ_PARK:     last_idx = CNT_W'(PARK_LEN - 1);
            default:     last_idx = '0;
        endcase
    end

    // Next state: a bit is consumed on each TCK rising edge
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        accept  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i && tgt_ok) begin
                    state_n = SQ_RESET;
                    cnt_n   = '0;
                    accept  = 1'b1;
                end
            end
            SQ_FINISH: begin
                if (fall_i) begin
                    state_n = SQ_IDLE;
                end
            end
            default: begin
                if (rise_i) begin
                    if (cnt_q == last_idx) begin
                        cnt_n = '0;
                        unique case (state_q)
                            SQ_RESET:    state_n = SQ_GO_IR;
                            SQ_GO_IR:    state_n = SQ_SHIFT_IR;
                            SQ_SHIFT_IR: state_n = SQ_GO_DR;
                            SQ_GO_DR:    state_n = SQ_SHIFT_DR;
                            SQ_SHIFT_DR: state_n = SQ_PARK;
                            default:     state_n = SQ_FINISH;
                        endcase
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Chain-wide scan images, padded with bypass fields and filler bits
    always_comb begin
        ir_vec = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            ir_vec[(NUM_DEV-1-d)*IR_LEN +: IR_LEN] =
                (d == int'(tgt_q)) ? USER_IR : BYPASS_IR;
        end
        dr_vec = DR_TOTAL'(wdata_q) << off;
    end

    // Bit that goes on the lines for the upcoming TCK period
    always_comb begin
        tms_vec = '0;
        tdi_vec = '0;
        unique case (state_n)
            SQ_RESET:    tms_vec = '1;
            SQ_GO_IR:    tms_vec = VEC_W'(GO_IR_PAT);
            SQ_SHIFT_IR: begin
                tms_vec = VEC_W'(1) << (IR_TOTAL - 1);
                tdi_vec = VEC_W'(ir_vec);
            end
            SQ_GO_DR:    tms_vec = VEC_W'(GO_DR_PAT);
            SQ_SHIFT_DR: begin
                tms_vec = VEC_W'(1) << (DR_TOTAL - 1);
                tdi_vec = VEC_W'(dr_vec);
            end
            SQ_PARK:     tms_vec = VEC_W'(PARK_PAT);
            default:     tms_vec = '0;
        endcase
        bit_tms = tms_vec[cnt_n];
        bit_tdi = tdi_vec[cnt_n];
    end

    assign in_window = (state_q == SQ_SHIFT_DR) &&
                       (int'(cnt_q) >= off) && (int'(cnt_q) < off + DR_LEN);

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms_o   <= 1'b0;
            tdi_o   <= 1'b0;
            tgt_q   <= '0;
            wdata_q <= '0;
            cap_q   <= '0;
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                tgt_q   <= target_i;
                wdata_q <= wdata_i;
            end
            if (accept || fall_i) begin
                tms_o <= bit_tms;
                tdi_o <= bit_tdi;
            end
            if (rise_i && in_window) begin
                cap_q <= {tdo_i, cap_q[DR_LEN-1:1]};
            end
            if (state_q == SQ_FINISH && fall_i) begin
                rdata_o <= cap_q;
                done_o  <= tap_rti_i;
            end
        end
    end

    assign accept_o = accept;
    assign busy_o   = (state_q != SQ_IDLE);

endmodule

// File: rtl/jtag_chain_seq.sv
module jtag_chain_seq
    import jtag_seq_pkg::*;
#(
    parameter int                NUM_DEV    = 3,
    parameter int                IR_LEN     = 3,
    parameter int                DR_LEN     = 8,
    parameter int                DIV_W      = 4,
    parameter int                RESET_TCKS = 8,
    parameter int                TGT_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    parameter logic [IR_LEN-1:0] USER_IR    = 3'b010,
    parameter logic [IR_LEN-1:0] BYPASS_IR  = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic [DR_LEN-1:0] wdata_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DR_LEN-1:0] rdata_o,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    input  logic              tdo_i
);

    logic       accept;
    logic       rise, fall;
    logic       tap_rti;
    tap_state_e tap_state;

    jtag_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .div_i  (div_i),
        .run_i  (busy_o),
        .tck_o  (tck_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    jtag_tap_tracker u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (rise && busy_o),
        .tms_i   (tms_o),
        .state_o (tap_state),
        .rti_o   (tap_rti)
    );

    jtag_seq_fsm #(
        .NUM_DEV    (NUM_DEV),
        .IR_LEN     (IR_LEN),
        .DR_LEN     (DR_LEN),
        .RESET_TCKS (RESET_TCKS),
        .TGT_W      (TGT_W),
        .USER_IR    (USER_IR),
        .BYPASS_IR  (BYPASS_IR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .target_i  (target_i),
        .wdata_i   (wdata_i),
        .rise_i    (rise),
        .fall_i    (fall),
        .tdo_i     (tdo_i),
        .tap_rti_i (tap_rti),
        .accept_o  (accept),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .tms_o     (tms_o),
        .tdi_o     (tdi_o),
        .rdata_o   (rdata_o)
    );

endmodule

// File: rtl/jtag_chain_seq_chk.sv
module jtag_chain_seq_chk
    import jtag_seq_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int DR_LEN  = 8,
    parameter int TGT_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [TGT_W-1:0]  target_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DR_LEN-1:0] rdata_o,
    input logic              tck_o,
    input logic              tms_o,
    input logic              tdi_o,
    input tap_state_e        tap_state
);

    assert_idle_tck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tck_o);

    assert_lines_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

    assert_rdata_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rdata_o));

    assert_done_at_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tap_state == TAP_RTI) && !busy_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_bad_target_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && int'(target_i) >= NUM_DEV) |=> !busy_o);

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && int'(target_i) < NUM_DEV) |=> busy_o);

endmodule

bind jtag_chain_seq jtag_chain_seq_chk #(
    .NUM_DEV (NUM_DEV),
    .DR_LEN  (DR_LEN),
    .TGT_W   (TGT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .target_i  (target_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .tck_o     (tck_o),
    .tms_o     (tms_o),
    .tdi_o     (tdi_o),
    .tap_state (tap_state)
);

// File: tb/jtag_chain_seq_tb.sv
module jtag_target_model #(
    parameter logic [7:0] INIT_USER = 8'h00,
    parameter logic [3:0] INIT_ST   = 4'd0
) (
    input  logic       tck,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic [7:0] user_o,
    output logic [3:0] st_o
);
    localparam logic [3:0] TLR = 0, RTI = 1, SDS = 2, CDR = 3, SHDR = 4, E1DR = 5,
        PDR = 6, E2DR = 7, UDR = 8, SIS = 9, CIR = 10, SHIR = 11, E1IR = 12,
        PIR = 13, E2IR = 14, UIR = 15;

    logic [3:0] st = INIT_ST;
    logic [2:0] ir = 3'b110;
    logic [2:0] ir_sr = 3'b000;
    logic [7:0] dr_sr = 8'h00;
    logic [7:0] user = INIT_USER;
    logic       byp = 1'b0;
    logic       sel;

    assign sel    = (ir == 3'b010);
    assign user_o = user;
    assign st_o   = st;
    initial tdo = 1'b0;

    function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
        case (s)
            TLR:  return m ? TLR  : RTI;
            RTI:  return m ? SDS  : RTI;
            SDS:  return m ? SIS  : CDR;
            CDR:  return m ? E1DR : SHDR;
            SHDR: return m ? E1DR : SHDR;
            E1DR: return m ? UDR  : PDR;
            PDR:  return m ? E2DR : PDR;
            E2DR: return m ? UDR  : SHDR;
            UDR:  return m ? SDS  : RTI;
            SIS:  return m ? TLR  : CIR;
            CIR:  return m ? E1IR : SHIR;
            SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR  : PIR;
            PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR  : SHIR;
            default: return m ? SDS : RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        case (st)
            TLR:  ir <= 3'b110;
            CIR:  ir_sr <= 3'b001;
            SHIR: ir_sr <= {tdi, ir_sr[2:1]};
            UIR:  ir <= ir_sr;
            CDR:  if (sel) dr_sr <= user; else byp <= 1'b0;
            SHDR: if (sel) dr_sr <= {tdi, dr_sr[7:1]}; else byp <= tdi;
            UDR:  if (sel) user <= dr_sr;
            default: ;
        endcase
        st <= nxt(st, tms);
    end

    always @(negedge tck) begin
        if (st == SHIR)      tdo <= ir_sr[0];
        else if (st == SHDR) tdo <= sel ? dr_sr[0] : byp;
        else                 tdo <= 1'b0;
    end
endmodule

module jtag_chain_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL_BITS = 38;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] target_i = '0;
    logic [7:0] wdata_i = '0;
    logic [3:0] div_i = '0;
    logic       busy_o, done_o, tck_o, tms_o, tdi_o, tdo_i;
    logic [7:0] rdata_o;
    logic       t0, t1;
    logic [7:0] u0, u1, u2;
    logic [3:0] s0, s1, s2;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] shadow [3];

    logic tms_log [64];
    logic tdi_log [64];
    int   rise_cyc [64];
    int   nbits = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    jtag_chain_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .wdata_i(wdata_i), .div_i(div_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
    );

    jtag_target_model #(.INIT_USER(8'h3C), .INIT_ST(4'd6))  u_d0 (
        .tck(tck_o), .tms(tms_o), .tdi(tdi_o), .tdo(t0), .user_o(u0), .st_o(s0));
    jtag_target_model #(.INIT_USER(8'hA5), .INIT_ST(4'd11)) u_d1 (
        .tck(tck_o), .tms(tms_o), .tdi(t0), .tdo(t1), .user_o(u1), .st_o(s1));
    jtag_target_model #(.INIT_USER(8'h96), .INIT_ST(4'd14)) u_d2 (
        .tck(tck_o), .tms(tms_o), .tdi(t1), .tdo(tdo_i), .user_o(u2), .st_o(s2));

    always @(posedge tck_o) begin
        if (nbits < 64) begin
            tms_log[nbits]  = tms_o;
            tdi_log[nbits]  = tdi_o;
            rise_cyc[nbits] = cyc;
            nbits = nbits + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_tms(input int i);
        logic [4:0] go_ir = 5'b00110;
        logic [3:0] go_dr = 4'b0011;
        if (i < 8)  return 1'b1;
        if (i < 13) return go_ir[i-8];
        if (i < 22) return (i == 21);
        if (i < 26) return go_dr[i-22];
        if (i < 36) return (i == 35);
        return (i == 36);
    endfunction

    function automatic logic exp_tdi(input int i, input int k, input logic [7:0] w);
        int j, dev, off;
        logic [2:0] code;
        if (i >= 13 && i < 22) begin
            j = i - 13;
            dev = 2 - j / 3;
            code = (dev == k) ? 3'b010 : 3'b110;
            return code[j % 3];
        end
        if (i >= 26 && i < 36) begin
            j = i - 26;
            off = 2 - k;
            if (j >= off && j < off + 8) return w[j-off];
            return 1'b0;
        end
        return 1'b0;
    endfunction

    function automatic logic [7:0] user_of(input int k);
        return (k == 0) ? u0 : (k == 1) ? u1 : u2;
    endfunction

    task automatic run_txn(input int k, input logic [7:0] w, input logic [3:0] dv,
                           input bit poke);
        int guard;
        bit seen, steady_bad, ph_rst, ph_ir, ph_dr, ph_park, tdi_ir, tdi_dr, per_bad;
        logic p_tck, p_tms, p_tdi;
        int actk_bits;
        nbits = 0;
        @(negedge clk);
        target_i = 2'(k); wdata_i = w; div_i = dv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        p_tck = tck_o; p_tms = tms_o; p_tdi = tdi_o;
        seen = 0; steady_bad = 0; guard = 0;
        while (!seen && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 40) begin
                target_i = 2'((k + 1) % 3); wdata_i = ~w; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (tck_o && p_tck && (tms_o != p_tms || tdi_o != p_tdi)) steady_bad = 1;
            p_tck = tck_o; p_tms = tms_o; p_tdi = tdi_o;
            if (done_o) seen = 1;
        end
        check(seen, "R9 done pulse seen", int'(seen), 1);
        check(!busy_o, "R9 busy low with done", int'(busy_o), 0);
        check(rdata_o == shadow[k], "R8 read byte", int'(rdata_o), int'(shadow[k]));
        check(!steady_bad, "R3 lines steady while tck high", int'(steady_bad), 0);
        actk_bits = nbits;
        check(actk_bits == TOTAL_BITS, "R7 tck period count", actk_bits, TOTAL_BITS);
        ph_rst = 0; ph_ir = 0; ph_dr = 0; ph_park = 0; tdi_ir = 0; tdi_dr = 0; per_bad = 0;
        for (int i = 0; i < TOTAL_BITS && i < actk_bits; i++) begin
            if (tms_log[i] != exp_tms(i)) begin
                if (i < 13) ph_rst = 1;
                else if (i < 22) ph_ir = 1;
                else if (i < 36) ph_dr = 1;
                else ph_park = 1;
            end
            if (i >= 13 && i < 22 && tdi_log[i] != exp_tdi(i, k, w)) tdi_ir = 1;
            if (i >= 26 && i < 36 && tdi_log[i] != exp_tdi(i, k, w)) tdi_dr = 1;
            if (i > 0 && rise_cyc[i] - rise_cyc[i-1] != 2 * (int'(dv) + 1)) per_bad = 1;
        end
        check(!ph_rst, "R4 reset and go-to-IR tms", int'(ph_rst), 0);
        check(!ph_ir && !tdi_ir, "R5 instruction scan stream", int'({ph_ir, tdi_ir}), 0);
        check(!ph_dr && !tdi_dr, "R6 data scan stream", int'({ph_dr, tdi_dr}), 0);
        check(!ph_park, "R7 closing tms", int'(ph_park), 0);
        check(!per_bad, "R2 tck period", int'(per_bad), 2 * (int'(dv) + 1));
        @(negedge clk);
        check(!done_o, "R9 done one cycle", int'(done_o), 0);
        check(!tck_o, "R2 tck low when idle", int'(tck_o), 0);
        check(s0 == 4'd1 && s1 == 4'd1 && s2 == 4'd1, "R11 devices in idle",
              int'({s2, s1, s0}), 12'h111);
        shadow[k] = w;
        check(u0 == shadow[0] && u1 == shadow[1] && u2 == shadow[2],
              "R11 user registers", int'({u2, u1, u0}), int'({shadow[2], shadow[1], shadow[0]}));
        check(user_of(k) == w, "R11 target holds byte", int'(user_of(k)), int'(w));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k;
        logic [7:0] w;
        logic [3:0] dv;
        void'($urandom(32'd2024));
        shadow[0] = 8'h3C; shadow[1] = 8'hA5; shadow[2] = 8'h96;
        repeat (4) @(negedge clk);
        check(!busy_o && !done_o && !tck_o && !tms_o && !tdi_o && rdata_o == 8'h00,
              "R1 reset state", int'({busy_o, done_o, tck_o, tms_o, tdi_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: invalid index is ignored
        nbits = 0;
        target_i = 2'd3; wdata_i = 8'h55; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        check(!busy_o && nbits == 0, "R10 index 3 ignored", int'(busy_o) + nbits, 0);
        check(rdata_o == 8'h00, "R10 rdata unchanged", int'(rdata_o), 0);

        // Directed: middle device, 0xF5 (R5/R6 example streams)
        run_txn(1, 8'hF5, 4'd1, 1'b0);
        run_txn(0, 8'h00, 4'd0, 1'b0);
        run_txn(2, 8'hFF, 4'd15, 1'b0);
        // R10: start during a transaction is ignored
        run_txn(0, 8'h81, 4'd2, 1'b1);
        run_txn(1, 8'h18, 4'd0, 1'b0);

        for (int n = 0; n < 20; n++) begin
            k  = $urandom_range(0, 2);
            w  = 8'($urandom_range(0, 255));
            dv = 4'($urandom_range(0, 3));
            run_txn(k, w, dv, (n % 5) == 2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule